// File: doc/BRIEF.md
# Maintenance Command Request Register

This block is a 32-bit command register that sits beside the command scheduler of a DRAM controller. It turns one-shot maintenance requests into level requests toward the scheduler. The requests are a refresh to each rank, a short ZQ calibration, and a PHY control-update. Each request stays asserted until the scheduler returns a one-cycle acknowledge. The acknowledge clears the request, so the request bit behaves as self-clearing.

Refresh and ZQ requests can come from one of two sources: software writes or dedicated external pins. A source selector inside the register picks which one is used. Firmware can change the selector only while the controller reset input is held low. Each request is gated by an automatic-mode disable flag. The ZQ request is also gated by the controller's power state. A request that arrives while its gate is closed is dropped. It never becomes pending and it is not replayed later. The control-update request always comes from software.

Top module: `maint_cmd_reg`

## Requirements
- R1: While `rst` is high, every request, every busy flag and `rd_data` are zero, and the source selector is cleared to software.
- R2: In software mode, writing 1 to bit r (r = 0 for rank 0, r = 1 for rank 1) with `auto_ref_off` high raises `ref_req[r]` and `ref_busy[r]` after the write edge.
- R3: A raised request stays high until a one-cycle acknowledge on its own ack input. The acknowledge drops the request, and the rank's busy flag with it, on the next edge.
- R4: A refresh or ZQ request that arrives while its disable flag (`auto_ref_off` or `auto_zq_off`) is low is discarded. It stays discarded even after the flag is raised later.
- R5: A ZQ request (bit 4 or `ext_zq`) is discarded while `pwr_state` is 2 (self-refresh), 3 (self-refresh power-down), 4 (deep power-down) or 5 (maximum saving). It is accepted in states 0 (normal) and 1 (init).
- R6: With the selector at 1, written bits 0, 1 and 4 have no effect. A high level on `ext_ref[r]` or `ext_zq` raises the matching request.
- R7: With the selector at 0, the `ext_ref` and `ext_zq` pins have no effect.
- R8: The selector takes `wr_data[31]` on a write only while `ctl_rst_n` is low. At any other time it keeps its value.
- R9: Writing 1 to a request that is already pending adds nothing, so a single acknowledge clears it. Writing 0 never cancels a pending request.
- R10: `rd_data` shows the state one edge after it changes. Bit 31 holds the selector, bit 5 the pending control-update, bit 4 the pending ZQ, and bits 1:0 the pending rank refreshes. All other bits read zero.
- R11: Writing 1 to bit 5 raises `upd_req` in either source mode, but only while `auto_upd_off` is high. Otherwise the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_rst_n | input | 1 | Controller reset, low while asserted; opens the selector for writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read-back value |
| auto_ref_off | input | 1 | Automatic refresh disabled; allows refresh requests |
| auto_zq_off | input | 1 | Automatic ZQ disabled; allows ZQ requests |
| auto_upd_off | input | 1 | Automatic control-update disabled; allows update requests |
| pwr_state | input | 3 | Controller power state, encoded as in R5 |
| ext_ref | input | 2 | Per-rank refresh request pins (hardware mode) |
| ext_zq | input | 1 | ZQ request pin (hardware mode) |
| ref_req | output | 2 | Per-rank refresh request to the scheduler |
| ref_ack | input | 2 | Per-rank refresh acknowledge |
| ref_busy | output | 2 | Per-rank refresh busy status |
| zq_req | output | 1 | Short ZQ calibration request |
| zq_ack | input | 1 | ZQ acknowledge |
| upd_req | output | 1 | PHY control-update request |
| upd_ack | input | 1 | Control-update acknowledge |

## Verification
The assertions assume that the scheduler sends an acknowledge only for a request that is currently raised, and that each acknowledge lasts one cycle. The bench follows this rule: it pulses an ack for exactly one cycle, and only after it has seen the matching request high. The hold-until-acknowledge property relies on this. The gating properties also assume that `pwr_state` and the disable flags change only between writes. The bench changes them only while `wr_en` is low.

// File: rtl/maint_cmd_pkg.sv
package maint_cmd_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL  = 3'd0,
    PS_INIT    = 3'd1,
    PS_SELFREF = 3'd2,
    PS_SR_PD   = 3'd3,
    PS_DEEP_PD = 3'd4,
    PS_MAXSAVE = 3'd5
  } pwr_state_e;

  // True in the power states where a short ZQ request must be discarded.
  function automatic logic zq_blocked(input logic [2:0] ps);
    return (ps == PS_SELFREF) || (ps == PS_SR_PD) ||
           (ps == PS_DEEP_PD) || (ps == PS_MAXSAVE);
  endfunction
endpackage

// File: rtl/maint_src_sel.sv
module maint_src_sel #(
  parameter int NUM_RANKS = 2
) (
  input  logic                 hw_src,
  input  logic                 wr_en,
  input  logic [NUM_RANKS-1:0] sw_ref,
  input  logic                 sw_zq,
  input  logic                 sw_upd,
  input  logic [NUM_RANKS-1:0] ext_ref,
  input  logic                 ext_zq,
  input  logic                 auto_ref_off,
  input  logic                 auto_zq_off,
  input  logic                 auto_upd_off,
  input  logic [2:0]           pwr_state,
  output logic [NUM_RANKS-1:0] ref_raise,
  output logic                 zq_raise,
  output logic                 upd_raise
);
  import maint_cmd_pkg::*;

  logic [NUM_RANKS-1:0] ref_src;
  logic                 zq_src;

  always_comb begin
    ref_src = hw_src ? ext_ref : (sw_ref & {NUM_RANKS{wr_en}});
    zq_src  = hw_src ? ext_zq  : (sw_zq & wr_en);
  end

  always_comb begin
    ref_raise = ref_src & {NUM_RANKS{auto_ref_off}};
    zq_raise  = zq_src & auto_zq_off & ~zq_blocked(pwr_state);
    upd_raise = wr_en & sw_upd & auto_upd_off;
  end
endmodule

// File: rtl/maint_req_slot.sv
module maint_req_slot (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic ack,
  output logic pend
);
  // A pending slot ignores new raises and waits only for its acknowledge.
  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (pend) pend <= ~ack;
    else           pend <= raise;
  end
endmodule

// File: rtl/maint_readback.sv
module maint_readback #(
  parameter int NUM_RANKS = 2,
  parameter int DATA_W    = 32,
  parameter int SEL_BIT   = 31,
  parameter int ZQ_BIT    = 4,
  parameter int UPD_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hw_src,
  input  logic [NUM_RANKS-1:0] ref_pend,
  input  logic                 zq_pend,
  input  logic                 upd_pend,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] view;

  always_comb begin
    view                     = '0;
    view[NUM_RANKS-1:0]      = ref_pend;
    view[ZQ_BIT]             = zq_pend;
    view[UPD_BIT]            = upd_pend;
    view[SEL_BIT]            = hw_src;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= view;
  end
endmodule

// File: rtl/maint_cmd_reg.sv
module maint_cmd_reg #(
  parameter int NUM_RANKS = 2,
  parameter int DATA_W    = 32,
  parameter int SEL_BIT   = 31,
  parameter int ZQ_BIT    = 4,
  parameter int UPD_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 auto_ref_off,
  input  logic                 auto_zq_off,
  input  logic                 auto_upd_off,
  input  logic [2:0]           pwr_state,
  input  logic [NUM_RANKS-1:0] ext_ref,
  input  logic                 ext_zq,
  output logic [NUM_RANKS-1:0] ref_req,
  input  logic [NUM_RANKS-1:0] ref_ack,
  output logic [NUM_RANKS-1:0] ref_busy,
  output logic                 zq_req,
  input  logic                 zq_ack,
  output logic                 upd_req,
  input  logic                 upd_ack
);
  localparam int NUM_SLOTS = NUM_RANKS + 2;
  localparam int ZQ_SLOT   = NUM_RANKS;
  localparam int UPD_SLOT  = NUM_RANKS + 1;

  logic                 hw_src;
  logic [NUM_RANKS-1:0] ref_raise;
  logic                 zq_raise;
  logic                 upd_raise;
  logic [NUM_SLOTS-1:0] slot_raise;
  logic [NUM_SLOTS-1:0] slot_ack;
  logic [NUM_SLOTS-1:0] slot_pend;
  logic                 unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  // Source selector: writable only while the controller reset is held low.
  always_ff @(posedge clk) begin
    if (rst)                     hw_src <= 1'b0;
    else if (wr_en && !ctl_rst_n) hw_src <= wr_data[SEL_BIT];
  end

  maint_src_sel #(.NUM_RANKS(NUM_RANKS)) u_src (
    .hw_src       (hw_src),
    .wr_en        (wr_en),
    .sw_ref       (wr_data[NUM_RANKS-1:0]),
    .sw_zq        (wr_data[ZQ_BIT]),
    .sw_upd       (wr_data[UPD_BIT]),
    .ext_ref      (ext_ref),
    .ext_zq       (ext_zq),
    .auto_ref_off (auto_ref_off),
    .auto_zq_off  (auto_zq_off),
    .auto_upd_off (auto_upd_off),
    .pwr_state    (pwr_state),
    .ref_raise    (ref_raise),
    .zq_raise     (zq_raise),
    .upd_raise    (upd_raise)
  );

  assign slot_raise = {upd_raise, zq_raise, ref_raise};
  assign slot_ack   = {upd_ack, zq_ack, ref_ack};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    maint_req_slot u_slot (
      .clk   (clk),
      .rst   (rst),
      .raise (slot_raise[s]),
      .ack   (slot_ack[s]),
      .pend  (slot_pend[s])
    );
  end

  assign ref_req  = slot_pend[NUM_RANKS-1:0];
  assign ref_busy = slot_pend[NUM_RANKS-1:0];
  assign zq_req   = slot_pend[ZQ_SLOT];
  assign upd_req  = slot_pend[UPD_SLOT];

  maint_readback #(
    .NUM_RANKS (NUM_RANKS),
    .DATA_W    (DATA_W),
    .SEL_BIT   (SEL_BIT),
    .ZQ_BIT    (ZQ_BIT),
    .UPD_BIT   (UPD_BIT)
  ) u_rb (
    .clk      (clk),
    .rst      (rst),
    .hw_src   (hw_src),
    .ref_pend (slot_pend[NUM_RANKS-1:0]),
    .zq_pend  (slot_pend[ZQ_SLOT]),
    .upd_pend (slot_pend[UPD_SLOT]),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/maint_cmd_reg_chk.sv
module maint_cmd_reg_chk #(
  parameter int NUM_RANKS = 2,
  parameter int DATA_W    = 32,
  parameter int ZQ_BIT    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ctl_rst_n,
  input logic                 hw_src,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wr_data,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 auto_ref_off,
  input logic                 auto_zq_off,
  input logic                 auto_upd_off,
  input logic [2:0]           pwr_state,
  input logic                 ext_zq,
  input logic [NUM_RANKS-1:0] ref_req,
  input logic [NUM_RANKS-1:0] ref_ack,
  input logic                 zq_req,
  input logic                 upd_req
);
  import maint_cmd_pkg::*;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && ref_req == '0 && !zq_req && !upd_req));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (rst)
      ref_req[r] && !ref_ack[r] |=> ref_req[r]);
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
      ref_req[r] && ref_ack[r] |=> !ref_req[r]);
    p_ref_gated_r4: assert property (@(posedge clk) disable iff (rst)
      !auto_ref_off && !ref_req[r] |=> !ref_req[r]);
  end

  p_zq_lowpower_r5: assert property (@(posedge clk) disable iff (rst)
    zq_blocked(pwr_state) && !zq_req |=> !zq_req);

  p_sw_zq_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    hw_src && !ext_zq && !zq_req |=> !zq_req);

  p_pin_zq_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    !hw_src && !(wr_en && wr_data[ZQ_BIT]) && !zq_req |=> !zq_req);

  p_sel_locked_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_rst_n |=> $stable(hw_src));

  p_zq_gated_r4: assert property (@(posedge clk) disable iff (rst)
    !auto_zq_off && !zq_req |=> !zq_req);

  p_upd_gated_r11: assert property (@(posedge clk) disable iff (rst)
    !auto_upd_off && !upd_req |=> !upd_req);
endmodule

bind maint_cmd_reg maint_cmd_reg_chk #(
  .NUM_RANKS (NUM_RANKS),
  .DATA_W    (DATA_W),
  .ZQ_BIT    (ZQ_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctl_rst_n    (ctl_rst_n),
  .hw_src       (hw_src),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .auto_ref_off (auto_ref_off),
  .auto_zq_off  (auto_zq_off),
  .auto_upd_off (auto_upd_off),
  .pwr_state    (pwr_state),
  .ext_zq       (ext_zq),
  .ref_req      (ref_req),
  .ref_ack      (ref_ack),
  .zq_req       (zq_req),
  .upd_req      (upd_req)
);

// File: tb/maint_cmd_reg_tb_top.sv
module maint_cmd_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        auto_ref_off = 1'b1, auto_zq_off = 1'b1, auto_upd_off = 1'b1;
  logic [2:0]  pwr_state = 3'd0;
  logic [1:0]  ext_ref = '0;
  logic        ext_zq = 1'b0;
  logic [1:0]  ref_req, ref_ack = '0, ref_busy;
  logic        zq_req, zq_ack = 1'b0, upd_req, upd_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  maint_cmd_reg dut_i (
    .clk(clk), .rst(rst), .ctl_rst_n(ctl_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .auto_ref_off(auto_ref_off),
    .auto_zq_off(auto_zq_off), .auto_upd_off(auto_upd_off),
    .pwr_state(pwr_state), .ext_ref(ext_ref), .ext_zq(ext_zq),
    .ref_req(ref_req), .ref_ack(ref_ack), .ref_busy(ref_busy),
    .zq_req(zq_req), .zq_ack(zq_ack), .upd_req(upd_req), .upd_ack(upd_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack_ref(input logic [1:0] m);
    ref_ack = m; @(negedge clk); ref_ack = '0;
  endtask

  task automatic ack_zq();
    zq_ack = 1'b1; @(negedge clk); zq_ack = 1'b0;
  endtask

  task automatic ack_upd();
    upd_ack = 1'b1; @(negedge clk); upd_ack = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 req", {ref_req, ref_busy, zq_req, upd_req}, 0);
    check("R1 rd_data", rd_data, 0);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_sw_refresh();
    wr(32'h1);
    check("R2 ref_req", ref_req, 2'b01);
    check("R2 ref_busy", ref_busy, 2'b01);
    tick(3);
    check("R3 held", ref_req, 2'b01);
    check("R10 rd ref0", rd_data, 32'h1);
    ack_ref(2'b01);
    check("R3 ack clears", {ref_req, ref_busy}, 0);
    wr(32'h2);
    check("R2 rank1", {ref_req, ref_busy}, 4'b1010);
    ack_ref(2'b10);
    check("R3 rank1 ack", ref_busy, 0);
  endtask

  task automatic t_gating();
    auto_ref_off = 1'b0; wr(32'h3);
    check("R4 ref dropped", {ref_req, ref_busy}, 0);
    auto_ref_off = 1'b1; tick(2);
    check("R4 not replayed", ref_req, 0);
    auto_zq_off = 1'b0; wr(32'h10);
    check("R4 zq dropped", zq_req, 0);
    auto_zq_off = 1'b1;
    auto_upd_off = 1'b0; wr(32'h20);
    check("R11 upd dropped", upd_req, 0);
    auto_upd_off = 1'b1; tick(1);
    check("R11 upd not replayed", upd_req, 0);
  endtask

  task automatic t_zq_power();
    for (int ps = 2; ps <= 5; ps++) begin
      pwr_state = 3'(ps); wr(32'h10);
      check($sformatf("R5 zq blocked ps%0d", ps), zq_req, 0);
    end
    for (int ps = 0; ps <= 1; ps++) begin
      pwr_state = 3'(ps); wr(32'h10);
      check($sformatf("R5 zq allowed ps%0d", ps), zq_req, 1);
      tick(1);
      check("R10 rd zq", rd_data, 32'h10);
      ack_zq();
      check("R3 zq ack", zq_req, 0);
    end
  endtask

  task automatic t_upd();
    wr(32'h20);
    check("R11 upd raised", upd_req, 1);
    tick(1);
    check("R10 rd upd", rd_data, 32'h20);
    ack_upd();
    check("R3 upd ack", upd_req, 0);
  endtask

  task automatic t_pending();
    wr(32'h1);
    wr(32'h0);
    check("R9 write 0 keeps", ref_req, 2'b01);
    wr(32'h1);
    ack_ref(2'b01);
    check("R9 single ack clears", ref_req, 0);
    tick(2);
    check("R9 nothing queued", ref_req, 0);
  endtask

  task automatic t_select();
    wr(32'h8000_0000); tick(1);
    check("R8 locked", rd_data, 32'h0);
    ctl_rst_n = 1'b0; wr(32'h8000_0000); ctl_rst_n = 1'b1; tick(1);
    check("R8 set in reset", rd_data, 32'h8000_0000);
    wr(32'h0); tick(1);
    check("R8 kept", rd_data, 32'h8000_0000);
  endtask

  task automatic t_hw_mode();
    wr(32'h13);
    check("R6 sw ignored", {ref_req, zq_req}, 0);
    ext_ref = 2'b10; @(negedge clk); ext_ref = '0;
    check("R6 pin ref", ref_req, 2'b10);
    tick(1);
    check("R10 rd hw", rd_data, 32'h8000_0002);
    ext_zq = 1'b1; @(negedge clk); ext_zq = 1'b0;
    check("R6 pin zq", zq_req, 1);
    ack_ref(2'b10); ack_zq();
    wr(32'h20);
    check("R11 upd in hw mode", upd_req, 1);
    ack_upd();
    ctl_rst_n = 1'b0; wr(32'h0); ctl_rst_n = 1'b1; tick(1);
    check("R8 back to sw", rd_data, 0);
  endtask

  task automatic t_pins_ignored();
    ext_ref = 2'b11; ext_zq = 1'b1; tick(2);
    ext_ref = '0; ext_zq = 1'b0;
    check("R7 pins ignored", {ref_req, zq_req}, 0);
  endtask

  initial begin
    t_reset();
    t_sw_refresh();
    t_gating();
    t_zq_power();
    t_upd();
    t_pending();
    t_select();
    t_hw_mode();
    t_pins_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule